// File: doc/BRIEF.md
# Configuration Image Load Retry Controller

This controller sequences the copy of a configuration image from an external non-volatile memory into a register bank after reset. It does not run the serial bus itself. Instead it starts each load attempt with a one-cycle request strobe. A separate mover performs the transfer and answers with a response strobe and an error flag. When an attempt fails, the controller waits a fixed number of idle cycles and then starts the whole load again. It gives up after a fixed number of attempts.

Progress is reported in one read-only status byte. The upper two bits give the outcome: `00` means the load is still running, `10` means it succeeded and `01` means it failed for good. The lower six bits count the attempts made so far. A one-cycle master-reset pulse puts the controller back to its starting point, just as the reset input does.

Top module: `cfg_load_retry`

## Requirements
- R1: While reset is held and on the first cycle after it, status reads 0x00 and no request is issued.
- R2: Each attempt begins with a request strobe that lasts exactly one cycle. The attempt count in status[5:0] goes up by one in the cycle after that strobe.
- R3: A response with the error flag low makes status[7:6] equal `10` from the next cycle on, and no further request is issued.
- R4: After a response with the error flag high that is not the last permitted attempt, exactly GAP_CYCLES cycles without a request pass before the next request strobe.
- R5: When the response to attempt number MAX_ATTEMPTS (default 64) has the error flag high, status[7:6] becomes `01` and no further request is issued.
- R6: The count field status[5:0] stops at 63 and never wraps to 0. The last attempt of a 64-attempt failure therefore shows 63.
- R7: The success and failure states, including the whole status byte, stay unchanged until reset or a master-reset pulse.
- R8: A master-reset pulse makes status read 0x00 in the next cycle, and a new request follows one cycle after that. If a response arrives in the same cycle as the pulse, the pulse takes priority.
- R9: A response strobe that arrives while no attempt is outstanding (during the idle gap) changes neither the status nor the timing of the next request.
- R10: The outcome code `11` never appears in status[7:6].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| masterRst | input | 1 | One-cycle pulse that restarts the loader |
| respValid | input | 1 | Marks the end of an attempt |
| respErr | input | 1 | Attempt failed; only meaningful when respValid is high |
| reqStart | output | 1 | One-cycle strobe that starts a load attempt |
| status | output | 8 | [7:6] outcome (00 running, 10 ok, 01 failed), [5:0] attempts made |

## Verification
Two events can land on the same edge: a master-reset pulse and the response that ends an outstanding attempt. The bench provokes this by driving both strobes in one cycle while an attempt is outstanding, with an error-free response that would otherwise record success. It then expects status 0x00 in the next cycle and a fresh request one cycle later, never the success code. A stray response injected in the idle gap gets a similar check: the bench measures the gap length and the count.

// File: rtl/cfg_load_retry_pkg.sv
package cfg_load_retry_pkg;

  typedef enum logic [1:0] {
    OUT_BUSY = 2'b00,
    OUT_FAIL = 2'b01,
    OUT_OK   = 2'b10
  } loadOutcome_e;

  typedef enum logic [2:0] {
    ST_ARM,
    ST_ISSUE,
    ST_WAIT,
    ST_GAP,
    ST_DONE_OK,
    ST_DONE_FAIL
  } loadState_e;

  // strobes from the sequencer into the datapath
  typedef struct packed {
    logic clear;
    logic incTry;
    logic loadGap;
    logic decGap;
    logic setOk;
    logic setFail;
  } loadStrobes_t;

endpackage

// File: rtl/cfg_load_retry_ctrl.sv
module cfg_load_retry_ctrl
  import cfg_load_retry_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         masterRst,
  input  logic         respValid,
  input  logic         respErr,
  input  logic         atLimit,
  input  logic         gapZero,
  output logic         reqStart,
  output loadStrobes_t stb
);

  loadState_e state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ARM;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    if (masterRst) begin
      stb.clear = 1'b1;
      stateNext = ST_ARM;
    end else begin
      unique case (state)
        ST_ARM:   stateNext = ST_ISSUE;
        ST_ISSUE: begin
          stb.incTry = 1'b1;
          stateNext  = ST_WAIT;
        end
        ST_WAIT: begin
          if (respValid) begin
            if (!respErr) begin
              stb.setOk = 1'b1;
              stateNext = ST_DONE_OK;
            end else if (atLimit) begin
              stb.setFail = 1'b1;
              stateNext   = ST_DONE_FAIL;
            end else begin
              stb.loadGap = 1'b1;
              stateNext   = ST_GAP;
            end
          end
        end
        ST_GAP: begin
          if (gapZero) stateNext = ST_ISSUE;
          else         stb.decGap = 1'b1;
        end
        ST_DONE_OK:   stateNext = ST_DONE_OK;
        ST_DONE_FAIL: stateNext = ST_DONE_FAIL;
        default:      stateNext = ST_ARM;
      endcase
    end
  end

  assign reqStart = (state == ST_ISSUE);

endmodule

// File: rtl/cfg_load_retry_dp.sv
module cfg_load_retry_dp
  import cfg_load_retry_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 64,
  parameter int GAP_CYCLES   = 4,
  parameter int CNT_W        = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  loadStrobes_t stb,
  output logic         atLimit,
  output logic         gapZero,
  output logic [7:0]   status
);

  localparam int TRY_W   = $clog2(MAX_ATTEMPTS + 1);
  localparam int GAP_W   = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
  localparam int CNT_MAX = (1 << CNT_W) - 1;

  logic [TRY_W-1:0] tries;
  logic [GAP_W-1:0] gapCnt;
  loadOutcome_e     outcome;
  logic [CNT_W-1:0] countField;

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      tries <= '0;
    end else if (stb.incTry && (tries != TRY_W'(MAX_ATTEMPTS))) begin
      tries <= tries + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear)  gapCnt <= '0;
    else if (stb.loadGap)    gapCnt <= GAP_W'(GAP_CYCLES - 1);
    else if (stb.decGap)     gapCnt <= gapCnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) outcome <= OUT_BUSY;
    else if (stb.setOk)     outcome <= OUT_OK;
    else if (stb.setFail)   outcome <= OUT_FAIL;
  end

  assign atLimit = (tries == TRY_W'(MAX_ATTEMPTS));
  assign gapZero = (gapCnt == '0);

  generate
    if (MAX_ATTEMPTS > CNT_MAX) begin : g_sat
      assign countField = (tries > TRY_W'(CNT_MAX)) ? CNT_W'(CNT_MAX)
                                                    : tries[CNT_W-1:0];
    end else begin : g_direct
      assign countField = CNT_W'(tries);
    end
  endgenerate

  assign status = {outcome, countField};

endmodule

// File: rtl/cfg_load_retry.sv
module cfg_load_retry
  import cfg_load_retry_pkg::*;
#(
  parameter int MAX_ATTEMPTS = 64,
  parameter int GAP_CYCLES   = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       masterRst,
  input  logic       respValid,
  input  logic       respErr,
  output logic       reqStart,
  output logic [7:0] status
);

  loadStrobes_t stb;
  logic         atLimit;
  logic         gapZero;

  cfg_load_retry_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .masterRst (masterRst),
    .respValid (respValid),
    .respErr   (respErr),
    .atLimit   (atLimit),
    .gapZero   (gapZero),
    .reqStart  (reqStart),
    .stb       (stb)
  );

  cfg_load_retry_dp #(
    .MAX_ATTEMPTS (MAX_ATTEMPTS),
    .GAP_CYCLES   (GAP_CYCLES),
    .CNT_W        (6)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .atLimit (atLimit),
    .gapZero (gapZero),
    .status  (status)
  );

endmodule

// File: rtl/cfg_load_retry_chk.sv
module cfg_load_retry_chk (
  input logic       clk,
  input logic       rstN,
  input logic       masterRst,
  input logic       respValid,
  input logic       respErr,
  input logic       reqStart,
  input logic [7:0] status
);

  // R10
  no_illegal_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    status[7:6] != 2'b11);

  // R2
  single_req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqStart |=> !reqStart);

  // R3
  ok_holds_chk: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (status[7:6] == 2'b10) |=> (status[7:6] == 2'b10) && !reqStart && $stable(status));

  // R5
  fail_holds_chk: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (status[7:6] == 2'b01) |=> (status[7:6] == 2'b01) && !reqStart && $stable(status));

  // R6
  count_saturates_chk: assert property (@(posedge clk) disable iff (!rstN || masterRst)
    (status[5:0] == 6'd63) |=> (status[5:0] == 6'd63));

  // R8
  restart_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    masterRst |=> (status == 8'h00) && !reqStart);

  // R2
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqStart |-> (status[7:6] == 2'b00));

  // R1
  always @(negedge clk) begin
    if (!rstN) begin
      reset_quiet_chk: assert (!reqStart);
    end
  end

endmodule

bind cfg_load_retry cfg_load_retry_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .masterRst (masterRst),
  .respValid (respValid),
  .respErr   (respErr),
  .reqStart  (reqStart),
  .status    (status)
);

// File: tb/cfg_load_retry_bench.sv
module cfg_load_retry_bench;

  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 4;
  localparam int MAXA       = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       masterRst = 1'b0;
  logic       respValid = 1'b0;
  logic       respErr = 1'b0;
  logic       reqStart;
  logic [7:0] status;

  int testCount = 0;
  int failCount = 0;
  int expCnt    = 0;
  int cycles    = 0;
  bit finished  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_load_retry #(.MAX_ATTEMPTS(MAXA), .GAP_CYCLES(GAP)) u_cfg_load_retry (
    .clk(clk), .rstN(rstN), .masterRst(masterRst),
    .respValid(respValid), .respErr(respErr),
    .reqStart(reqStart), .status(status)
  );

  function automatic int satCnt(int n);
    return (n > 63) ? 63 : n;
  endfunction

  function automatic logic [7:0] expFinal(int nFails);
    if (nFails >= MAXA) return {2'b01, 6'(satCnt(MAXA))};
    return {2'b10, 6'(satCnt(nFails + 1))};
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    testCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      finish();
    end
  end

  // wait at falling edges until a request is seen
  task automatic waitReq(input string req);
    int w = 0;
    while (!reqStart && w < 50) begin
      @(negedge clk);
      w++;
    end
    check(req, int'(reqStart), 1);
  endtask

  // run one attempt; returns at the falling edge after the response
  task automatic runAttempt(input bit err, input int lat, input bit stray);
    waitReq("R2");
    @(negedge clk);
    expCnt++;
    check("R2", int'(reqStart), 0);
    check("R6", int'(status[5:0]), satCnt(expCnt));
    for (int i = 0; i < lat; i++) @(negedge clk);
    respValid = 1'b1;
    respErr   = err;
    @(negedge clk);
    respValid = 1'b0;
    respErr   = 1'b0;
    if (err && expCnt < MAXA) begin
      int g = 0;
      while (!reqStart && g < 100) begin
        g++;
        if (stray && g == 1) begin
          respValid = 1'b1;
          respErr   = 1'b0;
        end
        @(negedge clk);
        respValid = 1'b0;
      end
      check("R4", g, GAP);
      if (stray) check("R9", int'(status), {2'b00, 6'(satCnt(expCnt))});
    end
  endtask

  task automatic pulseRestart();
    masterRst = 1'b1;
    @(negedge clk);
    masterRst = 1'b0;
    check("R8", int'(status), 8'h00);
    expCnt = 0;
    @(negedge clk);
    check("R8", int'(reqStart), 1);
  endtask

  task automatic loadRun(input int nFails, input bit randLat);
    for (int i = 0; i < MAXA; i++) begin
      bit err = (i < nFails);
      int lat = randLat ? int'($urandom_range(3)) : 0;
      bit stray = randLat ? 1'($urandom_range(1)) : 1'b0;
      runAttempt(err, lat, stray);
      if (!err) break;
    end
    check(nFails >= MAXA ? "R5" : "R3", int'(status), int'(expFinal(nFails)));
    begin
      logic [7:0] held = status;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (i == 3) begin
          respValid = 1'b1;
          respErr   = 1'b0;
        end else begin
          respValid = 1'b0;
        end
        if (reqStart || status != held) check("R7", int'(status), int'(held));
      end
      respValid = 1'b0;
      check("R7", int'(status), int'(held));
      check("R7", int'(reqStart), 0);
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", int'(status), 8'h00);
    check("R1", int'(reqStart), 0);
    rstN = 1'b1;
    check("R1", int'(status), 8'h00);

    // directed: three failures then success
    loadRun(3, 1'b0);

    // restart and immediate success
    pulseRestart();
    loadRun(0, 1'b0);

    // full failure, saturation of the count
    pulseRestart();
    loadRun(64, 1'b0);

    // success exactly on the 64th attempt
    pulseRestart();
    loadRun(63, 1'b1);

    // master reset in the same cycle as an ok response
    pulseRestart();
    @(negedge clk);
    respValid = 1'b1;
    respErr   = 1'b0;
    masterRst = 1'b1;
    @(negedge clk);
    respValid = 1'b0;
    masterRst = 1'b0;
    check("R8", int'(status), 8'h00);
    @(negedge clk);
    check("R8", int'(reqStart), 1);
    expCnt = 0;
    loadRun(1, 1'b0);

    // random runs
    for (int r = 0; r < 6; r++) begin
      int nf = int'($urandom_range(12));
      pulseRestart();
      loadRun(nf, 1'b1);
    end

    // a second full failure with random timing
    pulseRestart();
    loadRun(70, 1'b1);

    // hard reset from a terminal state
    rstN = 1'b0;
    @(negedge clk);
    check("R1", int'(status), 8'h00);
    rstN = 1'b1;
    expCnt = 0;
    loadRun(2, 1'b0);

    finish();
  end

endmodule